// File: doc/BRIEF.md
# Search Result Latency Pipeline

This block sits between a search engine's compare logic and the external SRAM port. Each cycle the compare logic may hand it one search result: a match address, a hit flag and a valid strobe. The block holds every result for a fixed number of clock cycles and then presents it as an SRAM read cycle. The address and the active-low chip-enable, address-latch-enable and write-enable lines change together.

The base delay is set by a 2-bit table-size field. Larger tables span more cascaded devices and need more time to settle on a winner. The result-valid and result-found status outputs trail the SRAM cycle by a further 0 to 7 cycles, set by a separate 3-bit hold field. Both fields are static configuration. They may change only while no search is in flight. Delays are counted from the cycle in which the result is presented, which is the clock cycle carrying the last command phases.

Top module: `search_latency_pipe`

## Requirements
- R1: With table-size code 2'b00, a result presented with `res_valid` high in cycle n appears on `sram_addr` with `sram_ce_n` and `sram_ale_n` low in cycle n+4.
- R2: Table-size code 2'b01 gives a base delay of 5 cycles and 2'b10 gives 6 cycles. The reserved code 2'b11 also gives 6 cycles.
- R3: For each search, `sram_ce_n` and `sram_ale_n` go low together for exactly one cycle, and `sram_we_n` stays high during it. When no search is being presented, `sram_ce_n`, `sram_ale_n` and `sram_we_n` are high and `sram_addr` is zero.
- R4: `stat_valid` is high for one cycle per search, at base delay plus the hold field value (0 to 7) cycles after the result was presented.
- R5: `stat_found` equals the hit flag of the search shown by `stat_valid`, and it is low whenever `stat_valid` is low.
- R6: A new search can be accepted in every cycle. Back-to-back searches come out in order, one per cycle, with none dropped.
- R7: In cycles with `res_valid` low, `res_addr` and `res_hit` have no effect on any output.
- R8: While `rst_n` is low, all SRAM strobes are high, `sram_addr` is zero, and both status outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tsize | input | 2 | Table-size code selecting the base delay |
| cfg_hold | input | 3 | Extra status delay in cycles |
| res_valid | input | 1 | A search result is presented this cycle |
| res_addr | input | 22 | Match address of the search |
| res_hit | input | 1 | Search found a matching entry |
| sram_addr | output | 22 | SRAM address, zero when idle |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_ale_n | output | 1 | SRAM address latch enable, active low |
| sram_we_n | output | 1 | SRAM write enable, held high (read) |
| stat_valid | output | 1 | Search status valid |
| stat_found | output | 1 | Search status found |

## Verification
The bench builds the block with its default parameters: a 22-bit address, base delays of 4, 5 and 6 cycles, and a 3-bit hold field. With these values the longest path through the delay line is 13 cycles, so every table-size code, including the reserved one, and both hold extremes 0 and 7 can be reached in short directed runs. A burst of three adjacent searches with hold 7 puts several results in flight at once in both the address stage and the status stage. Together these test ordering and alignment across the whole delay line.

// File: rtl/search_latency_pipe.sv
module search_latency_pipe #(
  parameter int AW        = 22,
  parameter int LAT_SMALL = 4,
  parameter int LAT_MID   = 5,
  parameter int LAT_LARGE = 6,
  parameter int HOLD_W    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_tsize,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic          res_valid,
  input  logic [AW-1:0] res_addr,
  input  logic          res_hit,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_ale_n,
  output logic          sram_we_n,
  output logic          stat_valid,
  output logic          stat_found
);
  localparam int HOLD_MAX = (1 << HOLD_W) - 1;
  localparam int DEPTH    = LAT_LARGE + HOLD_MAX;
  localparam int TAP_W    = $clog2(DEPTH);

  logic [DEPTH-1:0] vld_q;
  logic [AW:0]      dat_q [DEPTH];
  logic [TAP_W-1:0] base_tap, stat_tap;
  logic [AW:0]      base_dat, stat_dat;
  logic             base_vld;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[DEPTH-2:0], res_valid};

  always_ff @(posedge clk) begin
    dat_q[0] <= {res_hit, res_addr};
    for (int i = 1; i < DEPTH; i++) dat_q[i] <= dat_q[i-1];
  end

  always_comb
    case (cfg_tsize)
      2'b00:   base_tap = TAP_W'(LAT_SMALL - 1);
      2'b01:   base_tap = TAP_W'(LAT_MID - 1);
      default: base_tap = TAP_W'(LAT_LARGE - 1);
    endcase

  assign stat_tap = base_tap + TAP_W'(cfg_hold);
  assign base_vld = vld_q[base_tap];
  assign base_dat = dat_q[base_tap];
  assign stat_dat = dat_q[stat_tap];

  assign sram_addr  = base_vld ? base_dat[AW-1:0] : '0;
  assign sram_ce_n  = ~base_vld;
  assign sram_ale_n = ~base_vld;
  assign sram_we_n  = 1'b1;
  assign stat_valid = vld_q[stat_tap];
  assign stat_found = vld_q[stat_tap] & stat_dat[AW];
endmodule

module search_latency_pipe_chk #(
  parameter int AW = 22,
  parameter int HOLD_W = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_tsize,
  input logic [HOLD_W-1:0] cfg_hold,
  input logic          res_valid,
  input logic [AW-1:0] sram_addr,
  input logic          sram_ce_n,
  input logic          sram_ale_n,
  input logic          sram_we_n,
  input logic          stat_valid,
  input logic          stat_found
);
  assert_lat4_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tsize == 2'b00 && res_valid) |-> ##4 !sram_ce_n);
  assert_lat5_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tsize == 2'b01 && res_valid) |-> ##5 !sram_ce_n);
  assert_lat6_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tsize[1] && res_valid) |-> ##6 !sram_ce_n);
  assert_read_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> (sram_we_n && !sram_ale_n));
  assert_idle_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce_n |-> (sram_addr == '0));
  assert_hold0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hold == '0) |-> (stat_valid == !sram_ce_n));
  assert_hold7_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hold == 3'd7 && !sram_ce_n) |-> ##7 stat_valid);
  assert_found_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_found |-> stat_valid);
  always @(posedge clk)
    if (!rst_n) assert_reset_R8: assert (sram_ce_n && sram_ale_n && !stat_valid && !stat_found);
endmodule

bind search_latency_pipe search_latency_pipe_chk #(.AW(AW), .HOLD_W(HOLD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_tsize(cfg_tsize), .cfg_hold(cfg_hold),
  .res_valid(res_valid), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
  .sram_ale_n(sram_ale_n), .sram_we_n(sram_we_n), .stat_valid(stat_valid),
  .stat_found(stat_found));

// File: tb/search_latency_pipe_tb.sv
module search_latency_pipe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // vector: {tsize[27:26], hold[25:23], addr[22:1], hit[0]}
  localparam logic [27:0] VEC [NVEC] = '{
    {2'b00, 3'd0, 22'h000004, 1'b1},
    {2'b00, 3'd7, 22'h3FFFFC, 1'b0},
    {2'b01, 3'd2, 22'h123450, 1'b1},
    {2'b01, 3'd0, 22'h00ABC0, 1'b1},
    {2'b10, 3'd5, 22'h2AAAA8, 1'b1},
    {2'b10, 3'd7, 22'h155554, 1'b0},
    {2'b11, 3'd1, 22'h0F0F00, 1'b1},
    {2'b11, 3'd7, 22'h000001, 1'b1}};

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_tsize = 0;
  logic [2:0] cfg_hold = 0;
  logic res_valid = 0, res_hit = 0;
  logic [21:0] res_addr = 0;
  logic [21:0] sram_addr;
  logic sram_ce_n, sram_ale_n, sram_we_n, stat_valid, stat_found;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  search_latency_pipe dut_i (.*);

  function automatic int base_of(input logic [1:0] t);
    return (t == 2'b00) ? 4 : (t == 2'b01) ? 5 : 6;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [27:0] v);
    int lb, ls, seen_b, seen_s;
    logic [21:0] got_a;
    logic got_f, got_we, got_ale;
    cfg_tsize = v[27:26]; cfg_hold = v[25:23];
    repeat (2) @(negedge clk);
    lb = base_of(v[27:26]); ls = lb + int'(v[25:23]);
    seen_b = -1; seen_s = -1; got_a = '0; got_f = 0; got_we = 0; got_ale = 1;
    res_valid = 1; res_addr = v[22:1]; res_hit = v[0];
    @(negedge clk);
    res_valid = 0; res_addr = 22'h3FFFFF; res_hit = 1;
    for (int k = 1; k <= 16; k++) begin
      if (!sram_ce_n && seen_b < 0) begin
        seen_b = k; got_a = sram_addr; got_we = sram_we_n; got_ale = sram_ale_n;
      end
      if (stat_valid && seen_s < 0) begin seen_s = k; got_f = stat_found; end
      @(negedge clk);
    end
    check(v[27] ? "R2 base delay" : (v[26] ? "R2 base delay" : "R1 base delay"), seen_b, lb);
    check("R3 address", got_a, v[22:1]);
    check("R3 ale with ce", got_ale, 1'b0);
    check("R3 we high", got_we, 1'b1);
    check("R4 status delay", seen_s, ls);
    check("R5 found", got_f, v[0]);
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ce_cnt, sv_cnt;
    logic [21:0] bexp [3];
    logic fexp [3];
    res_valid = 1; res_hit = 1; res_addr = 22'h1;
    repeat (3) @(negedge clk);
    check("R8 reset ce", sram_ce_n, 1'b1);
    check("R8 reset ale", sram_ale_n, 1'b1);
    check("R8 reset addr", sram_addr, 22'h0);
    check("R8 reset status", {stat_valid, stat_found}, 2'b00);
    res_valid = 0;
    @(negedge clk); rst_n = 1;
    repeat (14) @(negedge clk);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // R7: junk with valid low
    cfg_tsize = 2'b00; cfg_hold = 3'd0;
    ce_cnt = 0; sv_cnt = 0;
    for (int k = 0; k < 20; k++) begin
      res_valid = 0; res_hit = k[0]; res_addr = 22'(k * 22'h1357);
      @(negedge clk);
      if (!sram_ce_n || sram_addr != 0) ce_cnt++;
      if (stat_valid || stat_found) sv_cnt++;
    end
    check("R7 no sram activity", ce_cnt, 0);
    check("R7 no status activity", sv_cnt, 0);

    // R6: back-to-back burst, tsize 01, hold 7
    cfg_tsize = 2'b01; cfg_hold = 3'd7;
    bexp = '{22'h0AAAA4, 22'h155558, 22'h3C3C3C};
    fexp = '{1'b1, 1'b0, 1'b1};
    repeat (2) @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      res_valid = 1; res_addr = bexp[j]; res_hit = fexp[j];
      @(negedge clk);
    end
    res_valid = 0;
    // first search presented in cycle 0; now in cycle 3
    @(negedge clk); // cycle 4
    check("R6 gap before burst", sram_ce_n, 1'b1);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk); // cycle 5+j
      check("R6 burst ce", sram_ce_n, 1'b0);
      check("R6 burst order", sram_addr, bexp[j]);
    end
    @(negedge clk); // cycle 8
    check("R3 single-cycle ce", sram_ce_n, 1'b1);
    repeat (4) @(negedge clk); // cycle 12
    for (int j = 0; j < 3; j++) begin
      check("R6 status burst valid", stat_valid, 1'b1);
      check("R5 status burst found", stat_found, fexp[j]);
      @(negedge clk);
    end
    check("R4 status single-cycle", stat_valid, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule